// File: doc/BRIEF.md
# Three-Link Doorbell Mailbox

This block lets a local processor and a remote processor ring each other with 32-bit doorbell words over three independent links. Each link has a receive status word and a transmit status word. Software changes a status word only through a write-one-to-set register and a write-one-to-clear register. The local processor uses an APB register port. The remote processor uses a simple register port into the same words, with the roles swapped: the remote side sets bits in the local receive word, and it reads and clears the local transmit word.

When the local receive word of a link is nonzero, that link's interrupt line is high. No interrupt marks the end of a transmission. The local sender sets bits in its transmit word and then polls that word at a fixed period. The message counts as consumed once the word reads zero, which happens after the remote side has read it and cleared it. Link 0 is the low-priority non-secure link, link 1 is the high-priority non-secure link, and link 2 is the secure link. Non-secure APB accesses cannot use link 2. Both sides run on one clock.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset every receive and transmit status word reads zero and all three interrupt lines are low.
- R2: A local APB write to a window's set register (window offset 0x8) ORs the written value into that window's status word, effective at the clock edge that ends the access phase.
- R3: A local APB write to a window's clear register (window offset 0x10) clears exactly the bits that are 1 in the written value and leaves every other bit unchanged.
- R4: The receive windows of links 0, 1 and 2 sit at byte offsets 0x000, 0x020 and 0x200, and each transmit window sits 0x100 above its receive window. The status word is at window offset 0x0. Reads of the set and clear registers return zero. Reads of unmapped offsets return zero without an error, and read data is zero outside a read access phase.
- R5: Each link's interrupt output is a register that is high in the cycle after the link's receive status word is nonzero, and low in the cycle after that word is zero.
- R6: An APB access with the non-secure protection bit set (apbProt[1]=1) to any register of link 2 raises apbSlvErr in its access phase, reads as zero, and changes no status word. The same access with apbProt[1]=0 works normally.
- R7: On the remote port, a write to the remote transmit-set address (receive base + 0x108) ORs its data into the local receive status. A remote read at the receive base + 0x000 returns the local transmit status, and a remote read at the receive base + 0x100 returns the local receive status. Remote writes to any other address have no effect.
- R8: A remote write to the receive base + 0x010 clears the written bits of the local transmit status, so a local poll of the transmit status then reads zero once every bit has been cleared.
- R9: When both ports write the same status word in one cycle, the next value is (status | set bits) & ~clear bits, so a bit that is set and cleared in the same cycle ends cleared.
- R10: apbReady is always high, so every APB transfer completes with no wait states, and a write is visible to a read that starts in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| apbSel | input | 1 | APB select |
| apbEnable | input | 1 | APB enable (access phase) |
| apbWrite | input | 1 | APB direction, 1 = write |
| apbProt | input | 3 | APB protection; bit 1 set marks a non-secure access |
| apbAddr | input | ADDR_W (12) | APB byte address |
| apbWdata | input | DATA_W (32) | APB write data |
| apbRdata | output | DATA_W (32) | APB read data |
| apbReady | output | 1 | Transfer ready, held high |
| apbSlvErr | output | 1 | Error response for a blocked secure-link access |
| rmtWe | input | 1 | Remote write strobe |
| rmtAddr | input | ADDR_W (12) | Remote byte address (mirrored map) |
| rmtWdata | input | DATA_W (32) | Remote write data |
| rmtRdata | output | DATA_W (32) | Remote read data for rmtAddr, combinational |
| irq | output | 3 | Per-link receive interrupt, registered |

## Verification
The bench builds the block with its defaults: a 32-bit data word and a 12-bit address. At that size the full offset map is reachable, including the secure link at 0x200/0x300, and any bit pattern can be driven into a status word. A behavioural model updates its six status words and three interrupt flags on every edge from the bus activity it observes, and it compares the interrupts on every cycle. Directed sequences cover the send-and-poll handshake, the secure-link error path, and same-cycle set/clear collisions on both words of a link. A random phase then mixes both ports and both protection levels, and ends by reading every status word back through both ports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int LINKS    = 3;
  localparam int SEC_LINK = 2;
  localparam int MAP_W    = 12;

  localparam logic [MAP_W-1:0] TX_SHIFT = 12'h100;
  localparam logic [MAP_W-1:0] OFF_STAT = 12'h000;
  localparam logic [MAP_W-1:0] OFF_SET  = 12'h008;
  localparam logic [MAP_W-1:0] OFF_CLR  = 12'h010;

  // receive-window base of each link; transmit window is TX_SHIFT above
  function automatic logic [MAP_W-1:0] linkBase(input int idx);
    case (idx)
      0:       return 12'h000;
      1:       return 12'h020;
      default: return 12'h200;
    endcase
  endfunction

  typedef struct packed {
    logic [LINKS-1:0] lSetRx;
    logic [LINKS-1:0] lClrRx;
    logic [LINKS-1:0] lSetTx;
    logic [LINKS-1:0] lClrTx;
    logic [LINKS-1:0] rSetRx;
    logic [LINKS-1:0] rClrTx;
    logic [LINKS-1:0] lRdRx;
    logic [LINKS-1:0] lRdTx;
    logic [LINKS-1:0] rRdRx;
    logic [LINKS-1:0] rRdTx;
  } mbStrobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [2:0]        apbProt,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic              rmtWe,
  input  logic [ADDR_W-1:0] rmtAddr,
  output mbStrobe_t         strb,
  output logic              apbSlvErr
);

  logic access;
  logic [LINKS-1:0] lSetRx, lClrRx, lSetTx, lClrTx;
  logic [LINKS-1:0] rSetRx, rClrTx;
  logic [LINKS-1:0] lRdRx, lRdTx, rRdRx, rRdTx;
  logic [LINKS-1:0] errVec;

  assign access = apbSel & apbEnable;

  for (genvar i = 0; i < LINKS; i++) begin : g_link
    localparam logic [MAP_W-1:0] RXB = linkBase(i);
    localparam logic [MAP_W-1:0] TXB = RXB + TX_SHIFT;

    logic guarded;
    logic hitRxSt, hitRxSet, hitRxClr;
    logic hitTxSt, hitTxSet, hitTxClr;
    logic anyHit, locOk;

    if (i == SEC_LINK) begin : g_sec
      assign guarded = apbProt[1];
    end else begin : g_open
      assign guarded = 1'b0;
    end

    assign hitRxSt  = (apbAddr == ADDR_W'(RXB + OFF_STAT));
    assign hitRxSet = (apbAddr == ADDR_W'(RXB + OFF_SET));
    assign hitRxClr = (apbAddr == ADDR_W'(RXB + OFF_CLR));
    assign hitTxSt  = (apbAddr == ADDR_W'(TXB + OFF_STAT));
    assign hitTxSet = (apbAddr == ADDR_W'(TXB + OFF_SET));
    assign hitTxClr = (apbAddr == ADDR_W'(TXB + OFF_CLR));
    assign anyHit   = hitRxSt | hitRxSet | hitRxClr | hitTxSt | hitTxSet | hitTxClr;
    assign locOk    = access & ~guarded;

    assign lSetRx[i] = locOk & apbWrite & hitRxSet;
    assign lClrRx[i] = locOk & apbWrite & hitRxClr;
    assign lSetTx[i] = locOk & apbWrite & hitTxSet;
    assign lClrTx[i] = locOk & apbWrite & hitTxClr;
    assign lRdRx[i]  = locOk & ~apbWrite & hitRxSt;
    assign lRdTx[i]  = locOk & ~apbWrite & hitTxSt;
    assign errVec[i] = access & guarded & anyHit;

    // remote view is mirrored: its transmit window feeds our receive word
    assign rSetRx[i] = rmtWe & (rmtAddr == ADDR_W'(TXB + OFF_SET));
    assign rClrTx[i] = rmtWe & (rmtAddr == ADDR_W'(RXB + OFF_CLR));
    assign rRdTx[i]  = (rmtAddr == ADDR_W'(RXB + OFF_STAT));
    assign rRdRx[i]  = (rmtAddr == ADDR_W'(TXB + OFF_STAT));
  end

  always_comb begin
    strb.lSetRx = lSetRx;
    strb.lClrRx = lClrRx;
    strb.lSetTx = lSetTx;
    strb.lClrTx = lClrTx;
    strb.rSetRx = rSetRx;
    strb.rClrTx = rClrTx;
    strb.lRdRx  = lRdRx;
    strb.lRdTx  = lRdTx;
    strb.rRdRx  = rRdRx;
    strb.rRdTx  = rRdTx;
  end

  assign apbSlvErr = |errVec;

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbStrobe_t                     strb,
  input  logic [DATA_W-1:0]             locWdata,
  input  logic [DATA_W-1:0]             rmtWdata,
  output logic [LINKS-1:0][DATA_W-1:0]  rxStat,
  output logic [LINKS-1:0][DATA_W-1:0]  txStat,
  output logic [LINKS-1:0]              irq,
  output logic [DATA_W-1:0]             locRdata,
  output logic [DATA_W-1:0]             rmtRdata
);

  for (genvar i = 0; i < LINKS; i++) begin : g_word
    logic [DATA_W-1:0] setRx, clrRx, setTx, clrTx;

    always_comb begin
      setRx = ({DATA_W{strb.lSetRx[i]}} & locWdata) | ({DATA_W{strb.rSetRx[i]}} & rmtWdata);
      clrRx = ({DATA_W{strb.lClrRx[i]}} & locWdata);
      setTx = ({DATA_W{strb.lSetTx[i]}} & locWdata);
      clrTx = ({DATA_W{strb.lClrTx[i]}} & locWdata) | ({DATA_W{strb.rClrTx[i]}} & rmtWdata);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxStat[i] <= '0;
        txStat[i] <= '0;
        irq[i]    <= 1'b0;
      end else begin
        rxStat[i] <= (rxStat[i] | setRx) & ~clrRx;
        txStat[i] <= (txStat[i] | setTx) & ~clrTx;
        irq[i]    <= |rxStat[i];
      end
    end
  end

  always_comb begin
    locRdata = '0;
    rmtRdata = '0;
    for (int i = 0; i < LINKS; i++) begin
      locRdata |= ({DATA_W{strb.lRdRx[i]}} & rxStat[i]) | ({DATA_W{strb.lRdTx[i]}} & txStat[i]);
      rmtRdata |= ({DATA_W{strb.rRdRx[i]}} & rxStat[i]) | ({DATA_W{strb.rRdTx[i]}} & txStat[i]);
    end
  end

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [2:0]        apbProt,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] apbRdata,
  output logic              apbReady,
  output logic              apbSlvErr,
  input  logic              rmtWe,
  input  logic [ADDR_W-1:0] rmtAddr,
  input  logic [DATA_W-1:0] rmtWdata,
  output logic [DATA_W-1:0] rmtRdata,
  output logic [LINKS-1:0]  irq
);

  mbStrobe_t                    strb;
  logic [LINKS-1:0][DATA_W-1:0] rxStat;
  logic [LINKS-1:0][DATA_W-1:0] txStat;

  assign apbReady = 1'b1;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .apbSel    (apbSel),
    .apbEnable (apbEnable),
    .apbWrite  (apbWrite),
    .apbProt   (apbProt),
    .apbAddr   (apbAddr),
    .rmtWe     (rmtWe),
    .rmtAddr   (rmtAddr),
    .strb      (strb),
    .apbSlvErr (apbSlvErr)
  );

  mbox_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .locWdata (apbWdata),
    .rmtWdata (rmtWdata),
    .rxStat   (rxStat),
    .txStat   (txStat),
    .irq      (irq),
    .locRdata (apbRdata),
    .rmtRdata (rmtRdata)
  );

endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         apbSel,
  input logic                         apbEnable,
  input logic                         apbWrite,
  input logic [2:0]                   apbProt,
  input logic [DATA_W-1:0]            apbRdata,
  input logic                         apbSlvErr,
  input logic                         rmtWe,
  input logic [LINKS-1:0]             irq,
  input mbStrobe_t                    strb,
  input logic [LINKS-1:0][DATA_W-1:0] rxStat,
  input logic [LINKS-1:0][DATA_W-1:0] txStat
);

  for (genvar i = 0; i < LINKS; i++) begin : g_chk
    // R5: interrupt register trails the receive word by one cycle
    p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (irq[i] == ($past(rxStat[i]) != '0)));

    // R2: receive bits rise only when a set strobe was present
    p_rx_rise_needs_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.lSetRx[i] || strb.rSetRx[i]) |=> ((rxStat[i] & ~$past(rxStat[i])) == '0));

    // R3: transmit bits fall only when a clear strobe was present
    p_tx_fall_needs_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.lClrTx[i] || strb.rClrTx[i]) |=> ((~txStat[i] & $past(txStat[i])) == '0));
  end

  // R6: a blocked access reads as zero
  p_err_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    apbSlvErr |-> (apbRdata == '0));

  // R6: error only in a non-secure access phase
  p_err_when_nonsecure_r6: assert property (@(posedge clk) disable iff (!rstN)
    apbSlvErr |-> (apbSel && apbEnable && apbProt[1]));

  // R6: a blocked local write leaves the secure words alone
  p_secure_untouched_r6: assert property (@(posedge clk) disable iff (!rstN)
    (apbSlvErr && !rmtWe) |=> ($stable(rxStat[SEC_LINK]) && $stable(txStat[SEC_LINK])));

  // R4: read data is zero outside a read access phase
  p_idle_rdata_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(apbSel && apbEnable && !apbWrite) |-> (apbRdata == '0));

endmodule

bind mbox_doorbell mbox_doorbell_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .apbSel    (apbSel),
  .apbEnable (apbEnable),
  .apbWrite  (apbWrite),
  .apbProt   (apbProt),
  .apbRdata  (apbRdata),
  .apbSlvErr (apbSlvErr),
  .rmtWe     (rmtWe),
  .irq       (irq),
  .strb      (strb),
  .rxStat    (rxStat),
  .txStat    (txStat)
);

// File: tb/mbox_doorbell_test.sv
`timescale 1ns/1ps
module mbox_doorbell_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        apbSel = 1'b0, apbEnable = 1'b0, apbWrite = 1'b0;
  logic [2:0]  apbProt = 3'b000;
  logic [11:0] apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic [31:0] apbRdata;
  logic        apbReady, apbSlvErr;
  logic        rmtWe = 1'b0;
  logic [11:0] rmtAddr = '0;
  logic [31:0] rmtWdata = '0;
  logic [31:0] rmtRdata;
  logic [2:0]  irq;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_doorbell uut (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbProt(apbProt), .apbAddr(apbAddr),
    .apbWdata(apbWdata), .apbRdata(apbRdata), .apbReady(apbReady),
    .apbSlvErr(apbSlvErr), .rmtWe(rmtWe), .rmtAddr(rmtAddr),
    .rmtWdata(rmtWdata), .rmtRdata(rmtRdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] mRx [3];
  logic [31:0] mTx [3];
  logic [2:0]  mIrq;
  int bases [3] = '{'h000, 'h020, 'h200};

  // link index, 0=receive/1=transmit window, register offset; link -1 when unmapped
  function automatic void mapAddr(input int a, output int lk, output int win, output int rg);
    lk = -1; win = 0; rg = 0;
    for (int l = 0; l < 3; l++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r <= 16; r += 8)
          if (a == bases[l] + w * 'h100 + r) begin lk = l; win = w; rg = r; end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin mRx[i] = 0; mTx[i] = 0; end
      mIrq = 0;
    end else begin
      logic [31:0] sR [3], cR [3], sT [3], cT [3];
      logic [2:0] nIrq;
      int lk, win, rg;
      for (int i = 0; i < 3; i++) begin
        nIrq[i] = (mRx[i] != 0);
        sR[i] = 0; cR[i] = 0; sT[i] = 0; cT[i] = 0;
      end
      if (apbSel && apbEnable && apbWrite) begin
        mapAddr(int'(apbAddr), lk, win, rg);
        if (lk >= 0 && !(lk == 2 && apbProt[1])) begin
          if (win == 0 && rg == 8)  sR[lk] |= apbWdata;
          if (win == 0 && rg == 16) cR[lk] |= apbWdata;
          if (win == 1 && rg == 8)  sT[lk] |= apbWdata;
          if (win == 1 && rg == 16) cT[lk] |= apbWdata;
        end
      end
      if (rmtWe) begin
        mapAddr(int'(rmtAddr), lk, win, rg);
        if (lk >= 0 && win == 1 && rg == 8)  sR[lk] |= rmtWdata;
        if (lk >= 0 && win == 0 && rg == 16) cT[lk] |= rmtWdata;
      end
      for (int i = 0; i < 3; i++) begin
        mRx[i] = (mRx[i] | sR[i]) & ~cR[i];
        mTx[i] = (mTx[i] | sT[i]) & ~cT[i];
      end
      mIrq = nIrq;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R5: interrupt lines compared with the model every cycle
  always @(negedge clk) if (rstN && !done) chk("R5 irq per cycle", {29'd0, irq}, {29'd0, mIrq});

  // ---------------- bus tasks ----------------
  task automatic apbWrX(input logic [11:0] a, input logic [31:0] d, input logic ns,
                        input bit withRmt, input logic [11:0] ra, input logic [31:0] rd,
                        output logic err);
    @(negedge clk);
    apbSel = 1; apbEnable = 0; apbWrite = 1; apbAddr = a; apbWdata = d; apbProt = {1'b0, ns, 1'b0};
    @(negedge clk);
    apbEnable = 1;
    if (withRmt) begin rmtWe = 1; rmtAddr = ra; rmtWdata = rd; end
    #1 err = apbSlvErr;
    chk("R10 ready", {31'd0, apbReady}, 32'd1);
    @(negedge clk);
    apbSel = 0; apbEnable = 0; apbWrite = 0; rmtWe = 0;
  endtask

  task automatic apbWr(input logic [11:0] a, input logic [31:0] d, input logic ns, output logic err);
    apbWrX(a, d, ns, 0, 12'h0, 32'h0, err);
  endtask

  task automatic apbRd(input logic [11:0] a, input logic ns, output logic [31:0] d, output logic err);
    @(negedge clk);
    apbSel = 1; apbEnable = 0; apbWrite = 0; apbAddr = a; apbProt = {1'b0, ns, 1'b0};
    @(negedge clk);
    apbEnable = 1;
    #1 d = apbRdata; err = apbSlvErr;
    @(negedge clk);
    apbSel = 0; apbEnable = 0;
  endtask

  task automatic rmtWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    rmtWe = 1; rmtAddr = a; rmtWdata = d;
    @(negedge clk);
    rmtWe = 0;
  endtask

  task automatic rmtRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rmtAddr = a;
    #1 d = rmtRdata;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", {29'd0, irq}, 32'd0);
    rstN = 1;

    // R1: every status word zero after reset
    for (int l = 0; l < 3; l++) begin
      apbRd(12'(bases[l]), 0, d, e);         chk("R1 rx after reset", d, 0);
      apbRd(12'(bases[l] + 'h100), 0, d, e); chk("R1 tx after reset", d, 0);
    end

    // R2: set ORs into transmit word of link 0
    apbWr(12'h108, 32'h0000_00A5, 0, e);
    apbRd(12'h100, 0, d, e); chk("R2 set first", d, 32'hA5);
    apbWr(12'h108, 32'h0000_0100, 0, e);
    apbRd(12'h100, 0, d, e); chk("R2 set or", d, 32'h1A5);

    // R7: remote sees local transmit at its receive status
    rmtRd(12'h000, d); chk("R7 remote reads tx", d, 32'h1A5);
    // R8: remote clears consumed bits; local poll reaches zero
    rmtWr(12'h010, 32'h0000_00A5);
    apbRd(12'h100, 0, d, e); chk("R8 partial clear", d, 32'h100);
    rmtWr(12'h010, 32'h0000_0100);
    apbRd(12'h100, 0, d, e); chk("R8 poll reads zero", d, 32'h0);

    // R7 and R5: remote rings link 1
    rmtWr(12'h128, 32'h0000_0003);
    @(negedge clk); #1 chk("R5 irq1 rises", {29'd0, irq}, 32'b010);
    apbRd(12'h020, 0, d, e); chk("R7 local rx1", d, 32'h3);
    rmtRd(12'h120, d); chk("R7 remote reads rx", d, 32'h3);
    // R3: local clears received bits
    apbWr(12'h030, 32'h1, 0, e);
    apbRd(12'h020, 0, d, e); chk("R3 clear one bit", d, 32'h2);
    apbWr(12'h030, 32'h2, 0, e);
    @(negedge clk); #1 chk("R5 irq1 falls", {29'd0, irq}, 32'b000);

    // R4: set/clear read as zero, unmapped read zero without error
    apbWr(12'h008, 32'h0000_0F00, 0, e);
    apbRd(12'h008, 0, d, e); chk("R4 set reads zero", d, 0);
    apbRd(12'h010, 0, d, e); chk("R4 clear reads zero", d, 0);
    apbRd(12'h000, 0, d, e); chk("R4 rx0 at 0x000", d, 32'hF00);
    apbRd(12'h004, 0, d, e); chk("R4 unmapped data", d, 0);
    chk("R4 unmapped no error", {31'd0, e}, 0);
    apbRd(12'h400, 1, d, e); chk("R4 far unmapped", d, 0);
    apbWr(12'h010, 32'hFFFF_FFFF, 0, e);

    // R6: non-secure access to link 2
    apbWr(12'h308, 32'h0000_00FF, 1, e);
    chk("R6 ns write error", {31'd0, e}, 1);
    apbRd(12'h300, 0, d, e); chk("R6 ns write ignored", d, 0);
    apbWr(12'h308, 32'h0000_000F, 0, e);
    chk("R6 secure write ok", {31'd0, e}, 0);
    apbRd(12'h300, 0, d, e); chk("R6 secure read", d, 32'hF);
    apbRd(12'h300, 1, d, e); chk("R6 ns read zero", d, 0);
    chk("R6 ns read error", {31'd0, e}, 1);
    rmtWr(12'h308, 32'h0000_0040);
    @(negedge clk); #1 chk("R5 irq2 rises", {29'd0, irq}, 32'b100);
    apbWr(12'h210, 32'hFFFF_FFFF, 1, e);
    apbRd(12'h200, 0, d, e); chk("R6 ns clear ignored", d, 32'h40);
    apbWr(12'h210, 32'h0000_0040, 0, e);
    apbRd(12'h200, 0, d, e); chk("R6 secure clear", d, 0);
    rmtWr(12'h018, 32'hFFFF);
    apbRd(12'h000, 0, d, e); chk("R7 stray remote write", d, 0);

    // R9: same-cycle set and clear from both ports
    apbWr(12'h108, 32'h0000_0033, 0, e);
    apbWrX(12'h108, 32'h0000_00F0, 0, 1, 12'h010, 32'h0000_0030, e);
    apbRd(12'h100, 0, d, e); chk("R9 tx combine", d, 32'hC3);
    apbWrX(12'h010, 32'h0000_0001, 0, 1, 12'h108, 32'h0000_0003, e);
    apbRd(12'h000, 0, d, e); chk("R9 rx combine", d, 32'h2);

    // R9 R2 R3: random mix of both ports
    for (int n = 0; n < 300; n++) begin
      int lk = $urandom % 3;
      int op = $urandom % 6;
      logic [31:0] v = $urandom;
      logic ns = ($urandom % 4) == 0;
      logic [11:0] ra = (op % 2) ? 12'(bases[lk] + 'h108) : 12'(bases[lk] + 'h010);
      case (op)
        0: apbWr(12'(bases[lk] + 'h008), v, ns, e);
        1: apbWr(12'(bases[lk] + 'h010), v, ns, e);
        2: apbWr(12'(bases[lk] + 'h108), v, ns, e);
        3: apbWrX(12'(bases[lk] + 'h110), v, ns, 1, ra, $urandom, e);
        4: rmtWr(ra, v);
        default: apbWrX(12'(bases[lk] + 'h008), v, ns, 1, ra, $urandom, e);
      endcase
    end
    for (int l = 0; l < 3; l++) begin
      apbRd(12'(bases[l]), 0, d, e);         chk("R9 random rx", d, mRx[l]);
      apbRd(12'(bases[l] + 'h100), 0, d, e); chk("R9 random tx", d, mTx[l]);
      rmtRd(12'(bases[l]), d);               chk("R7 random remote tx", d, mTx[l]);
      rmtRd(12'(bases[l] + 'h100), d);       chk("R7 random remote rx", d, mRx[l]);
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule